// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt request pin and turns activity on it into a sticky event flag and an interrupt request. Four run-time control bits select how it behaves. One enables the pin as an interrupt source. One picks the active sense (falling edges and low levels, or rising edges and high levels). One picks between edge-only sensing and sensing of both edges and levels. One decides whether a captured event also drives the interrupt request or only sets the flag for software to poll. Software clears the flag with a one-cycle acknowledge pulse.

The pin is brought into the clock domain through a chain of synchronizer flops. An edge is found by comparing the newest synchronized sample with the sample from the cycle before. Alongside this clocked path, a purely combinational wake output follows the raw pin when it is enabled and at its active level. A clock controller can use it while the system clocks are stopped. The incoming asynchronous reset is asserted at once and released in step with the clock.

Top module: `eirq_pin_detector`

## Requirements
- R1: While reset is held, and after it is released with the pin idle high, `flag_o` and `irq_o` are 0.
- R2: While `pin_en_i` is 0, no edge or level on the pin sets `flag_o`. With the pin disabled and at its active level, `wake_o` is 0.
- R3: With `pol_rise_i` = 0, falling edges (and low levels in level mode) are events. With `pol_rise_i` = 1, rising edges (and high levels) are events. Edges of the opposite sense, and a change of `pol_rise_i` while the pin is steady, set nothing in edge-only mode.
- R4: With the default two synchronizer stages, a pin change made between clock edges shows on `flag_o` after the third following rising clock edge, and not after the second.
- R5: Once set, `flag_o` stays 1 until `ack_i` is sampled high. The flag is then 0 after that edge, provided no new event is present.
- R6: In edge-only mode (`lvl_mode_i` = 0), an acknowledge clears the flag even while the pin is still held at its active level, and the held level does not set the flag again.
- R7: In level mode (`lvl_mode_i` = 1), the flag is set while the synchronized pin is at its active level, and an acknowledge in that time leaves it at 1. Once the pin leaves the active level, an acknowledge clears it.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1, and it follows `irq_en_i` in the same cycle. With `irq_en_i` = 0 the flag still sets (polling use).
- R9: When an acknowledge and a new event meet at the same clock edge, the flag is 1 after that edge.
- R10: `wake_o` is 1 when `pin_en_i` is 1 and the raw pin is at its active level, with no clock edge needed and even while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin |
| pin_en_i | input | 1 | Pin acts as interrupt source when 1 |
| pol_rise_i | input | 1 | 0: falling/low active, 1: rising/high active |
| lvl_mode_i | input | 1 | 0: edges only, 1: edges and levels |
| irq_en_i | input | 1 | Event drives the interrupt request when 1 |
| ack_i | input | 1 | Software acknowledge, clears the flag |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous wake indication |

## Verification
The pin is driven with single falling edges, single rising edges, long holds at the active level and returns to idle, under each polarity and mode. This separates edge sensing from level sensing and shows which polarity is in force. Acknowledges are placed while the pin is still active, after it has gone back to idle, and exactly on the edge where a new event lands. These placements distinguish clearing in edge-only mode, the held flag in level mode, and the rule that a new event wins over a clear. Samples taken two and three cycles after a pin change pin down the synchronizer latency. The pin enable, the interrupt enable and the wake output are toggled while the flag is set and while it is clear.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef struct packed {
    logic pin_en;
    logic pol_rise;
    logic lvl_mode;
    logic irq_en;
  } eirq_ctrl_t;

  // True when a pin value matches the selected active sense.
  function automatic logic eirq_is_active(input logic pin, input logic pol_rise);
    return pin ~^ pol_rise;
  endfunction

endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pin_en_i,
  input  logic pol_rise_i,
  input  logic lvl_mode_i,
  output logic set_o,
  output logic lvl_act_o
);
  import eirq_pkg::*;

  logic prev_q;
  logic prev_d;
  logic rose;
  logic fell;
  logic edge_hit;

  always_comb begin
    prev_d    = sync_i;
    rose      = sync_i & ~prev_q;
    fell      = ~sync_i & prev_q;
    edge_hit  = pol_rise_i ? rose : fell;
    lvl_act_o = eirq_is_active(sync_i, pol_rise_i);
    set_o     = pin_en_i & (edge_hit | (lvl_mode_i & lvl_act_o));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (ack_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !ack_i |=> flag_q);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !set_i |=> !flag_q);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/eirq_pin_detector.sv
module eirq_pin_detector #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned RST_SYNC_STAGES = 2,
  parameter logic        PIN_IDLE        = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pin_en_i,
  input  logic pol_rise_i,
  input  logic lvl_mode_i,
  input  logic irq_en_i,
  input  logic ack_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);
  import eirq_pkg::*;

  eirq_ctrl_t ctrl;
  logic       rst_int_n;
  logic       pin_sync;
  logic       ev_set;
  logic       lvl_act;
  logic       flag;

  always_comb begin
    ctrl.pin_en   = pin_en_i;
    ctrl.pol_rise = pol_rise_i;
    ctrl.lvl_mode = lvl_mode_i;
    ctrl.irq_en   = irq_en_i;
  end

  eirq_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  eirq_detect #(.RST_VAL(PIN_IDLE)) u_detect (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sync_i     (pin_sync),
    .pin_en_i   (ctrl.pin_en),
    .pol_rise_i (ctrl.pol_rise),
    .lvl_mode_i (ctrl.lvl_mode),
    .set_o      (ev_set),
    .lvl_act_o  (lvl_act)
  );

  eirq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (ev_set),
    .ack_i  (ack_i),
    .flag_o (flag)
  );

  assign flag_o = flag;
  assign irq_o  = flag & ctrl.irq_en;
  // Clock-free path: raw pin, no synchronizer.
  assign wake_o = ctrl.pin_en & eirq_is_active(pin_i, ctrl.pol_rise);

  a_r2_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pin_en_i && !flag_o |=> !flag_o);

  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_en_i && lvl_mode_i && lvl_act |=> flag_o);

  a_r8_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    !flag_o |-> !irq_o);
endmodule

// File: tb/eirq_pin_detector_bench.sv
module eirq_pin_detector_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pin, pin_en, pol_rise, lvl_mode, irq_en, ack;
  logic flag_o, irq_o, wake_o;

  eirq_pin_detector u_eirq_pin_detector (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(pin_en),
    .pol_rise_i(pol_rise), .lvl_mode_i(lvl_mode), .irq_en_i(irq_en),
    .ack_i(ack), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  typedef struct {
    int    at;
    logic  flag;
    logic  irq;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   n_chk  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int d, logic f, logic i, string req);
    exp_t e;
    e.at = cyc + d; e.flag = f; e.irq = i; e.req = req;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Monitor: compares scheduled expectations at the falling edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        check(q[i].req, "flag_o", flag_o, q[i].flag);
        check(q[i].req, "irq_o", irq_o, q[i].irq);
        q.delete(i);
      end
    end
  end

  initial begin
    rst_n = 0; pin = 1; pin_en = 0; pol_rise = 0; lvl_mode = 0; irq_en = 0; ack = 0;
    // R10: wake works with reset held and no clock edge
    #1 pin_en = 1; pin = 0;
    #1 check("R10", "wake_o", wake_o, 1'b1);
    check("R1", "flag_o", flag_o, 1'b0);
    check("R1", "irq_o", irq_o, 1'b0);
    pin = 1;
    #1 check("R10", "wake_o", wake_o, 1'b0);
    pin_en = 0;
    tick(1);
    rst_n = 1;
    expect_at(1, 0, 0, "R1");
    tick(6);

    // R2: disabled pin, level mode, active low level
    lvl_mode = 1; pin = 0;
    #1 check("R2", "wake_o", wake_o, 1'b0);
    tick(6);
    expect_at(0, 0, 0, "R2");
    pin = 1; lvl_mode = 0;
    tick(6);

    // R3/R4/R8: falling edge, polling use
    pin_en = 1;
    tick(6);
    expect_at(0, 0, 0, "R3 idle high");
    pin = 0;
    expect_at(2, 0, 0, "R4 not yet");
    expect_at(3, 1, 0, "R4 third edge, R8 poll");
    tick(4);

    // R5: sticky, then acknowledge
    pin = 1;
    tick(6);
    expect_at(0, 1, 0, "R5 sticky");
    ack = 1;
    expect_at(1, 0, 0, "R5 ack");
    tick(1);
    ack = 0;
    tick(2);

    // R6: edge-only, ack while pin held active
    pin = 0;
    expect_at(3, 1, 0, "R6 set");
    tick(5);
    ack = 1;
    expect_at(1, 0, 0, "R6 ack while held");
    tick(1);
    ack = 0;
    expect_at(4, 0, 0, "R6 no re-set");
    tick(5);
    pin = 1;
    tick(5);
    expect_at(0, 0, 0, "R3 rising ignored");
    tick(1);

    // R3: rising polarity
    pol_rise = 1;
    expect_at(3, 0, 0, "R3 polarity change alone");
    tick(4);
    pin = 0;
    tick(5);
    expect_at(0, 0, 0, "R3 falling ignored");
    pin = 1;
    expect_at(3, 1, 0, "R3 rising");
    tick(4);

    // R8: interrupt gating
    irq_en = 1;
    expect_at(0, 1, 1, "R8 enable");
    tick(1);
    irq_en = 0;
    expect_at(0, 1, 0, "R8 disable");
    tick(1);
    irq_en = 1; ack = 1;
    expect_at(1, 0, 0, "R8 follows flag");
    tick(1);
    ack = 0;
    tick(2);

    // R9: ack and new edge at the same clock edge
    pin = 0;
    tick(5);
    pin = 1;
    expect_at(3, 1, 1, "R9 setup");
    tick(4);
    pin = 0;
    tick(5);
    pin = 1;
    tick(2);
    ack = 1;
    expect_at(1, 1, 1, "R9 event wins");
    tick(1);
    ack = 0;
    expect_at(1, 1, 1, "R9 stays");
    tick(2);
    ack = 1;
    expect_at(1, 0, 0, "R9 cleanup");
    tick(1);
    ack = 0;
    tick(2);

    // R7: level mode, active low
    pol_rise = 0; lvl_mode = 1;
    tick(4);
    pin = 0;
    expect_at(3, 1, 1, "R7 level set");
    tick(5);
    ack = 1;
    expect_at(1, 1, 1, "R7 ack ignored");
    tick(1);
    ack = 0;
    tick(1);
    pin = 1;
    tick(4);
    ack = 1;
    expect_at(1, 0, 0, "R7 ack after release");
    tick(1);
    ack = 0;
    tick(3);

    // R2/R7/R10: disable while level active, then re-enable
    pin_en = 0; pin = 0;
    #1 check("R2", "wake_o", wake_o, 1'b0);
    tick(6);
    expect_at(0, 0, 0, "R2 disabled level");
    pin_en = 1;
    #1 check("R10", "wake_o", wake_o, 1'b1);
    expect_at(1, 1, 1, "R7 re-enable level");
    tick(3);

    foreach (q[i]) begin
      n_chk++; n_bad++;
      $display("FAIL %s unchecked expectation actual=none expected=cycle %0d", q[i].req, q[i].at);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule